// File: doc/BRIEF.md
# Exception and Interrupt Next-PC Controller

This block sits beside the decoder of a single-cycle 32-bit RISC core. It turns faults and external requests into forced procedure calls. It owns the program counter and the next-PC multiplexer. Every cycle it either passes the normal decoder's controls through or overrides them.

A synchronous exception is raised when the decoder reports an unimplemented opcode, or when an operand fault is flagged (for example a zero divisor). It sends the next fetch to the handler vector 0x4. An asynchronous interrupt request sends it to 0x8 instead.

In both cases the controller steers the register file to write PC+4 of the abandoned instruction into the exception-pointer register 30, and it blocks the memory write. A handler that wants to retry the instruction subtracts 4 from the saved pointer. When a fault and an interrupt request arrive in the same cycle, the fault wins. The interrupt is kept in a small two-state holding machine (states HOLD_NONE and HOLD_PENDING) until the next instruction boundary that has no fault.

The holding machine has four named transitions:
- NONE→PENDING happens when a request meets a fault.
- PENDING→PENDING happens while faults keep arriving.
- PENDING→NONE happens when the held interrupt is taken.
- NONE→NONE covers every other cycle.

Top module: `exc_ctl`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the PC is 0x00000000 and no interrupt is held.
- R2: With no fault and no interrupt, the pcsel output equals the decoder's select, where 0 means PC+4, 1 means the branch target and 2 means the jump target. The PC at the next rising edge is the value selected.
- R3: When op_known is 0 (unimplemented opcode), pcsel is 3 and the next PC is 0x00000004.
- R4: When opnd_fault is 1, the controller behaves exactly as in R3.
- R5: When an interrupt is taken (irq_req is 1 or an interrupt is held, and there is no fault), pcsel is 4 and the next PC is 0x00000008.
- R6: In any exception or interrupt cycle, the following outputs are forced: wasel is 1, waddr is 30, wdsel is 0 (the PC+4 source), reg_we is 1 and mem_we is 0. The pc_plus4 output always equals pc+4.
- R7: In a normal cycle, wasel is 0, waddr equals the rc field, and wdsel, reg_we and mem_we equal the decoder's values.
- R8: When a fault and irq_req occur in the same cycle, the fault is served (pcsel 3). The interrupt is then taken (pcsel 4) at the next cycle with no fault, even if irq_req has dropped by then.
- R9: Once a held interrupt has been taken, it is cleared. The following normal cycle is not redirected.
- R10: A decoder select in the range 3 to 7 in a normal cycle is treated as 0 (PC+4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_known | input | 1 | Decoder says the opcode is implemented |
| opnd_fault | input | 1 | Operand not acceptable (e.g. zero divisor) |
| irq_req | input | 1 | External interrupt request |
| dec_pcsel | input | 3 | Decoder's next-PC select |
| dec_wdsel | input | 2 | Decoder's write-data select |
| dec_regwe | input | 1 | Decoder's register write enable |
| dec_memwe | input | 1 | Decoder's memory write enable |
| rc_field | input | 5 | Destination register field of the instruction |
| br_target | input | 32 | Branch target address |
| jmp_target | input | 32 | Jump target address |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | PC+4, the return address |
| pcsel | output | 3 | Final next-PC select |
| wasel | output | 1 | 1 selects register 30 as the write address |
| waddr | output | 5 | Register file write address |
| wdsel | output | 2 | Final write-data select |
| reg_we | output | 1 | Final register write enable |
| mem_we | output | 1 | Final memory write enable |

## Verification
The bench drives the decoder's three legal selects, a reserved select, each fault source alone, and an interrupt alone. It checks the override controls against the pass-through controls, with the decoder's values chosen so that every override visibly differs. A same-cycle fault-plus-interrupt pattern, followed by a clean cycle with the request removed, separates a design that keeps the interrupt from one that drops it or ranks it first. A further clean cycle shows that the held interrupt does not fire twice. Reset applied mid-run shows that the PC and the held interrupt are cleared.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [2:0] {
        PC_SEQ   = 3'd0,
        PC_BR    = 3'd1,
        PC_JMP   = 3'd2,
        PC_ILLOP = 3'd3,
        PC_INTR  = 3'd4
    } pcsel_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_SYNC = 2'd1,
        CAUSE_IRQ  = 2'd2
    } cause_t;

    typedef enum logic {
        HOLD_NONE    = 1'b0,
        HOLD_PENDING = 1'b1
    } hold_t;

    localparam logic [1:0] WD_PC4 = 2'd0;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
(
    input  logic   op_known,
    input  logic   opnd_fault,
    input  logic   irq_eff,
    output logic   sync_exc,
    output cause_t cause
);
    assign sync_exc = !op_known || opnd_fault;

    always_comb begin
        if (sync_exc)
            cause = CAUSE_SYNC;
        else if (irq_eff)
            cause = CAUSE_IRQ;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/exc_irq_hold.sv
module exc_irq_hold
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic sync_exc,
    output logic irq_eff
);
    hold_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= HOLD_NONE;
        else
            state_q <= state_d;
    end

    always_comb begin
        irq_eff = irq_req || (state_q == HOLD_PENDING);
        state_d = state_q;
        unique case (state_q)
            HOLD_NONE:    if (irq_req && sync_exc) state_d = HOLD_PENDING;
            HOLD_PENDING: if (!sync_exc)           state_d = HOLD_NONE;
            default:                               state_d = HOLD_NONE;
        endcase
    end
endmodule

// File: rtl/exc_pc_unit.sv
module exc_pc_unit
    import exc_pkg::*;
#(
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  RESET_VEC = '0,
    parameter logic [XLEN-1:0]  ILLOP_VEC = XLEN'(4),
    parameter logic [XLEN-1:0]  INTR_VEC  = XLEN'(8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pcsel_t          sel,
    input  logic [XLEN-1:0] br_target,
    input  logic [XLEN-1:0] jmp_target,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_plus4
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);
    logic [XLEN-1:0] pc_next;

    assign pc_plus4 = pc + STEP;

    always_comb begin
        unique case (sel)
            PC_BR:    pc_next = br_target;
            PC_JMP:   pc_next = jmp_target;
            PC_ILLOP: pc_next = ILLOP_VEC;
            PC_INTR:  pc_next = INTR_VEC;
            default:  pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_VEC;
        else
            pc <= pc_next;
    end
endmodule

// File: rtl/exc_ctl.sv
module exc_ctl
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RAW    = 5,
    parameter int XP_REG = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_known,
    input  logic            opnd_fault,
    input  logic            irq_req,
    input  logic [2:0]      dec_pcsel,
    input  logic [1:0]      dec_wdsel,
    input  logic            dec_regwe,
    input  logic            dec_memwe,
    input  logic [RAW-1:0]  rc_field,
    input  logic [XLEN-1:0] br_target,
    input  logic [XLEN-1:0] jmp_target,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_plus4,
    output logic [2:0]      pcsel,
    output logic            wasel,
    output logic [RAW-1:0]  waddr,
    output logic [1:0]      wdsel,
    output logic            reg_we,
    output logic            mem_we
);
    localparam logic [RAW-1:0] XP_ADDR = RAW'(XP_REG);

    logic   sync_exc, irq_eff;
    cause_t cause;
    pcsel_t sel;

    exc_irq_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .sync_exc (sync_exc),
        .irq_eff  (irq_eff)
    );

    exc_classify u_cls (
        .op_known   (op_known),
        .opnd_fault (opnd_fault),
        .irq_eff    (irq_eff),
        .sync_exc   (sync_exc),
        .cause      (cause)
    );

    always_comb begin
        sel    = PC_SEQ;
        wasel  = 1'b0;
        wdsel  = dec_wdsel;
        reg_we = dec_regwe;
        mem_we = dec_memwe;
        unique case (cause)
            CAUSE_SYNC: begin
                sel    = PC_ILLOP;
                wasel  = 1'b1;
                wdsel  = WD_PC4;
                reg_we = 1'b1;
                mem_we = 1'b0;
            end
            CAUSE_IRQ: begin
                sel    = PC_INTR;
                wasel  = 1'b1;
                wdsel  = WD_PC4;
                reg_we = 1'b1;
                mem_we = 1'b0;
            end
            default: begin
                if (dec_pcsel <= 3'd2)
                    sel = pcsel_t'(dec_pcsel);
                else
                    sel = PC_SEQ;
            end
        endcase
    end

    assign pcsel = sel;
    assign waddr = wasel ? XP_ADDR : rc_field;

    exc_pc_unit #(.XLEN(XLEN)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .br_target  (br_target),
        .jmp_target (jmp_target),
        .pc         (pc),
        .pc_plus4   (pc_plus4)
    );
endmodule

module exc_ctl_chk #(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_known,
    input logic            opnd_fault,
    input logic            irq_req,
    input logic [XLEN-1:0] br_target,
    input logic [XLEN-1:0] jmp_target,
    input logic [XLEN-1:0] pc,
    input logic [2:0]      pcsel,
    input logic [RAW-1:0]  waddr,
    input logic            reg_we,
    input logic            mem_we
);
    a_r3_illop_select: assert property (@(posedge clk) disable iff (!rst_n)
        !op_known |-> pcsel == 3'd3);

    a_r4_fault_vector: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_fault |=> pc == XLEN'(4));

    a_r5_intr_vector: assert property (@(posedge clk) disable iff (!rst_n)
        pcsel == 3'd4 |=> pc == XLEN'(8));

    a_r6_save_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (pcsel == 3'd3 || pcsel == 3'd4) |-> (reg_we && !mem_we && waddr == RAW'(30)));

    a_r8_intr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (!op_known || opnd_fault)) |=> (pcsel == 3'd3 || pcsel == 3'd4));

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        pcsel == 3'd0 |=> pc == $past(pc) + XLEN'(4));

    a_r2_branch: assert property (@(posedge clk) disable iff (!rst_n)
        pcsel == 3'd1 |=> pc == $past(br_target));

    a_r2_jump: assert property (@(posedge clk) disable iff (!rst_n)
        pcsel == 3'd2 |=> pc == $past(jmp_target));
endmodule

bind exc_ctl exc_ctl_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (.*);

// File: tb/sim_exc_ctl.sv
module sim_exc_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_known = 1'b1, opnd_fault = 1'b0, irq_req = 1'b0;
    logic [2:0]  dec_pcsel = 3'd0;
    logic [1:0]  dec_wdsel = 2'd1;
    logic        dec_regwe = 1'b0, dec_memwe = 1'b1;
    logic [4:0]  rc_field = 5'd5;
    logic [31:0] br_target = 32'h100, jmp_target = 32'h200;
    logic [31:0] pc, pc_plus4;
    logic [2:0]  pcsel;
    logic        wasel, reg_we, mem_we;
    logic [4:0]  waddr;
    logic [1:0]  wdsel;

    int checks = 0, fails = 0;

    exc_ctl u0 (.*);

    always #5 clk = ~clk;

    // {known, fault, irq, dec_pcsel[2:0], exp_pcsel[2:0], exp_exc}
    localparam int NV = 8;
    localparam logic [9:0] VEC [NV] = '{
        {3'b100, 3'd0, 3'd0, 1'b0},   // R2 sequential
        {3'b100, 3'd1, 3'd1, 1'b0},   // R2 branch
        {3'b100, 3'd2, 3'd2, 1'b0},   // R2 jump
        {3'b100, 3'd5, 3'd0, 1'b0},   // R10 reserved select
        {3'b000, 3'd0, 3'd3, 1'b1},   // R3 unknown opcode
        {3'b110, 3'd1, 3'd3, 1'b1},   // R4 operand fault
        {3'b101, 3'd2, 3'd4, 1'b1},   // R5 interrupt
        {3'b000, 3'd2, 3'd3, 1'b1}    // R3 unknown opcode with jump
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_pc(input logic [2:0] s, input logic [31:0] cur);
        case (s)
            3'd1: return br_target;
            3'd2: return jmp_target;
            3'd3: return 32'h4;
            3'd4: return 32'h8;
            default: return cur + 32'd4;
        endcase
    endfunction

    task automatic drive(input logic k, input logic f, input logic i, input logic [2:0] d);
        @(negedge clk);
        op_known = k; opnd_fault = f; irq_req = i; dec_pcsel = d;
        #1;
    endtask

    task automatic check_ctl(input string req, input logic exc, input logic [2:0] exp_sel);
        chk(req, {29'd0, pcsel}, {29'd0, exp_sel});
        chk(req, {31'd0, wasel}, {31'd0, exc});
        chk(req, {27'd0, waddr}, exc ? 32'd30 : {27'd0, rc_field});
        chk(req, {30'd0, wdsel}, exc ? 32'd0 : {30'd0, dec_wdsel});
        chk(req, {31'd0, reg_we}, exc ? 32'd1 : {31'd0, dec_regwe});
        chk(req, {31'd0, mem_we}, exc ? 32'd0 : {31'd0, dec_memwe});
        chk("R6 pc_plus4", pc_plus4, pc + 32'd4);
    endtask

    task automatic step_and_check_pc(input string req, input logic [2:0] s);
        logic [31:0] exp;
        exp = next_pc(s, pc);
        @(posedge clk); #2;
        chk(req, pc, exp);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #2;
        chk("R1 reset pc", pc, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 first pc", pc, 32'h0);
        check_ctl("R1 idle no held irq", 1'b0, 3'd0);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][9], VEC[v][8], VEC[v][7], VEC[v][6:4]);
            check_ctl($sformatf("R2-table entry %0d", v), VEC[v][0], VEC[v][3:1]);
            step_and_check_pc($sformatf("R2 R3 R4 R5 R10 next pc entry %0d", v), VEC[v][3:1]);
        end

        // R8: fault and interrupt together
        drive(1'b0, 1'b0, 1'b1, 3'd1);
        check_ctl("R8 fault wins", 1'b1, 3'd3);
        step_and_check_pc("R8 fault vector", 3'd3);
        drive(1'b1, 1'b0, 1'b0, 3'd1);
        check_ctl("R8 held irq taken", 1'b1, 3'd4);
        step_and_check_pc("R8 irq vector", 3'd4);
        // R9: held interrupt cleared
        drive(1'b1, 1'b0, 1'b0, 3'd2);
        check_ctl("R9 no second irq", 1'b0, 3'd2);
        step_and_check_pc("R9 jump after clear", 3'd2);

        // R8 with operand fault and repeated faults
        drive(1'b1, 1'b1, 1'b1, 3'd0);
        check_ctl("R8 operand fault wins", 1'b1, 3'd3);
        step_and_check_pc("R8 vector", 3'd3);
        drive(1'b0, 1'b0, 1'b0, 3'd0);
        check_ctl("R8 still fault", 1'b1, 3'd3);
        step_and_check_pc("R8 vector again", 3'd3);
        drive(1'b1, 1'b0, 1'b0, 3'd0);
        check_ctl("R8 held through faults", 1'b1, 3'd4);
        step_and_check_pc("R8 irq vector late", 3'd4);

        // R7 with a different rc field
        rc_field = 5'd17;
        drive(1'b1, 1'b0, 1'b0, 3'd0);
        check_ctl("R7 pass-through rc", 1'b0, 3'd0);
        step_and_check_pc("R7 seq", 3'd0);

        // R1: reset mid-run clears held interrupt
        drive(1'b0, 1'b0, 1'b1, 3'd0);
        @(negedge clk);
        rst_n = 1'b0;
        op_known = 1'b1; irq_req = 1'b0;
        @(posedge clk); #2;
        chk("R1 reset pc mid-run", pc, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check_ctl("R1 held cleared by reset", 1'b0, 3'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule